// File: doc/BRIEF.md
# Serial Timing Frame Receiver

This block takes a single-wire, Manchester-coded timing line and turns it into decoded machine-timing information. It waits on the idle-high line for the first falling edge and uses that edge as the start of a frame. From there it samples the centre of every half-bit cell, using a clock that runs a fixed multiple of the bit rate. It checks that each bit cell holds a valid transition, that the parity agrees with the data and that a stop bit closes the frame. Each frame that passes is split into an accelerator selector, a frame type, an 8-bit code and a 16-bit payload.

A frame whose accelerator field does not match the configured selector is dropped, unless the selector is the wildcard. The frame type then decides what happens. Event frames raise a one-cycle strobe with their code and payload for downstream counters. Two time-of-day frames together build a 32-bit seconds value. Telegram frames fill the hidden half of a two-bank store, and a separate swap frame exchanges the two halves. Software therefore always reads a complete and stable set of telegram values. Rejected frames leave every output untouched except a reject counter and a last-cause field.

Top module: `timing_frame_rx`

## Requirements
- R1: The line idles high. Each bit lasts OVS clock cycles and is sent as two halves: a 1 is high then low, and a 0 is low then high. A frame is a start bit of value 0, then 32 data bits most significant first, then a parity bit, then a stop bit of value 1.
- R2: Data bits [31:28] are the accelerator selector, [27:24] the type, [23:16] the code and [15:0] the payload.
- R3: An accepted frame of type 0x1 pulses evt_stb_o for one cycle, with evt_code_o and evt_payload_o carrying its code and payload.
- R4: A bit whose two halves are equal rejects the frame. rej_count_o increments and last_err_o bit 0 is set.
- R5: With the default even sense, the parity bit must equal the XOR of the 32 data bits. A mismatch rejects the frame, increments rej_count_o and sets last_err_o bit 1.
- R6: A stop bit that is not 1 rejects the frame, increments rej_count_o and sets last_err_o bit 2.
- R7: A rejected frame changes no event, time or telegram output.
- R8: A frame is acted on only when its selector equals cfg_acc_i or cfg_acc_i is 0xF.
- R9: A type 0x2 frame holds the upper 16 bits of time. A type 0x3 frame accepted no more than MS_CYCLES cycles after it loads utc_sec_o with {upper, its payload} and pulses utc_stb_o.
- R10: A type 0x3 frame that has no pending upper half, or that arrives later than MS_CYCLES cycles after it, is discarded and utc_sec_o keeps its value.
- R11: A type 0x4 frame writes its payload into the hidden bank at the index given by its code. Codes at or above TG_DEPTH are ignored. tg_rd_data_o shows the visible bank at tg_rd_idx_i.
- R12: A type 0x5 frame swaps the banks, so the previously hidden bank becomes the visible one.
- R13: After reset every output and every telegram entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| line_i | input | 1 | Manchester timing line |
| cfg_acc_i | input | 4 | Accepted selector, 0xF accepts all |
| tg_rd_idx_i | input | $clog2(TG_DEPTH) | Telegram read index |
| evt_stb_o | output | 1 | Event strobe |
| evt_code_o | output | 8 | Event code |
| evt_payload_o | output | 16 | Event payload |
| utc_sec_o | output | 32 | Assembled time of day |
| utc_stb_o | output | 1 | Time updated pulse |
| tg_rd_data_o | output | 16 | Visible telegram entry |
| rej_count_o | output | CNT_W | Rejected frame count |
| last_err_o | output | 3 | Cause of last rejection: stop, parity, Manchester |

## Verification
The bench builds the block with OVS = 16, TG_DEPTH = 8 and MS_CYCLES = 1000. A shallow store lets every entry be read back after each swap, and a code of 9 lands just past the top of the store. A one-millisecond window of 1000 cycles is short enough for a late low half to be reached by a short idle gap, while a low half sent straight after its upper half still falls inside it. The even-parity variant is the one built.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
   localparam logic [3:0] TY_EVENT    = 4'h1;
   localparam logic [3:0] TY_UTC_HI   = 4'h2;
   localparam logic [3:0] TY_UTC_LO   = 4'h3;
   localparam logic [3:0] TY_TGM      = 4'h4;
   localparam logic [3:0] TY_TGM_SWAP = 4'h5;
   localparam logic [3:0] ACC_ANY     = 4'hF;

   localparam int ERR_MANCH = 0;
   localparam int ERR_PAR   = 1;
   localparam int ERR_STOP  = 2;

   typedef struct packed {
      logic [3:0]  acc;
      logic [3:0]  typ;
      logic [7:0]  code;
      logic [15:0] payload;
   } frm_word_t;
endpackage

// File: rtl/tfr_sampler.sv
module tfr_sampler #(
   parameter int OVS        = 16,
   parameter bit PARITY_ODD = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        line_i,
   output logic        frm_valid_o,
   output logic [31:0] frm_word_o,
   output logic [2:0]  err_o
);
   localparam int CW     = $clog2(OVS);
   localparam int Q1     = OVS / 4;
   localparam int Q3     = (3 * OVS) / 4;
   localparam int N_DATA = 32;

   if (OVS < 4 || (OVS % 4) != 0) begin : g_bad_ovs
      $error("tfr_sampler: OVS must be a multiple of 4, at least 4");
   end

   logic [1:0]    sync_q;
   logic          line, prev_q, busy_q, h1_q, par_q, bad_m_q;
   logic [CW-1:0] cnt_q;
   logic [5:0]    bidx_q;
   logic [31:0]   shreg_q;
   logic          exp_par;

   assign line = sync_q[1];

   if (PARITY_ODD) begin : g_odd
      assign exp_par = ~(^shreg_q);
   end else begin : g_even
      assign exp_par = ^shreg_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q      <= 2'b11;
         prev_q      <= 1'b1;
         busy_q      <= 1'b0;
         h1_q        <= 1'b0;
         par_q       <= 1'b0;
         bad_m_q     <= 1'b0;
         cnt_q       <= '0;
         bidx_q      <= '0;
         shreg_q     <= '0;
         frm_valid_o <= 1'b0;
         frm_word_o  <= '0;
         err_o       <= '0;
      end else begin
         sync_q      <= {sync_q[0], line_i};
         prev_q      <= line;
         frm_valid_o <= 1'b0;
         err_o       <= '0;
         if (!busy_q) begin
            if (prev_q && !line) begin
               busy_q  <= 1'b1;
               cnt_q   <= CW'(1);
               bidx_q  <= '0;
               bad_m_q <= 1'b0;
            end
         end else begin
            cnt_q <= (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + CW'(1);
            if (cnt_q == CW'(OVS - 1)) bidx_q <= bidx_q + 6'd1;
            if (cnt_q == CW'(Q1)) h1_q <= line;
            if (cnt_q == CW'(Q3)) begin
               if (h1_q == line) bad_m_q <= 1'b1;
               if (bidx_q >= 6'd1 && bidx_q <= 6'(N_DATA))
                  shreg_q <= {shreg_q[30:0], h1_q};
               if (bidx_q == 6'(N_DATA + 1)) par_q <= h1_q;
               if (bidx_q == 6'(N_DATA + 2)) begin
                  busy_q                <= 1'b0;
                  err_o[tfr_pkg::ERR_MANCH] <= bad_m_q | (h1_q == line);
                  err_o[tfr_pkg::ERR_PAR]   <= (par_q != exp_par);
                  err_o[tfr_pkg::ERR_STOP]  <= !h1_q;
                  frm_valid_o <= !(bad_m_q | (h1_q == line)) && (par_q == exp_par) && h1_q;
                  frm_word_o  <= shreg_q;
               end
            end
         end
      end
   end

   AST_VALID_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(frm_valid_o && (|err_o))); // R4
endmodule

// File: rtl/tfr_dispatch.sv
module tfr_dispatch #(
   parameter int MS_CYCLES = 50000,
   parameter int TG_DEPTH  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        frm_valid_i,
   input  logic [31:0]                 frm_word_i,
   input  logic [3:0]                  cfg_acc_i,
   input  logic [$clog2(TG_DEPTH)-1:0] tg_rd_idx_i,
   output logic                        evt_stb_o,
   output logic [7:0]                  evt_code_o,
   output logic [15:0]                 evt_payload_o,
   output logic [31:0]                 utc_sec_o,
   output logic                        utc_stb_o,
   output logic [15:0]                 tg_rd_data_o
);
   import tfr_pkg::*;
   localparam int IDX_W = $clog2(TG_DEPTH);
   localparam int AGE_W = $clog2(MS_CYCLES + 1);

   if (TG_DEPTH < 2 || TG_DEPTH > 256 || (TG_DEPTH & (TG_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tfr_dispatch: TG_DEPTH must be a power of two from 2 to 256");
   end
   if (MS_CYCLES < 2) begin : g_bad_ms
      $error("tfr_dispatch: MS_CYCLES must be at least 2");
   end

   frm_word_t        w;
   logic             hit, front_q, hi_pend_q;
   logic [15:0]      hi_q;
   logic [AGE_W-1:0] age_q;
   logic [15:0]      bank_q [2][TG_DEPTH];

   assign w   = frm_word_t'(frm_word_i);
   assign hit = frm_valid_i && (cfg_acc_i == ACC_ANY || w.acc == cfg_acc_i);
   assign tg_rd_data_o = bank_q[front_q][tg_rd_idx_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_stb_o     <= 1'b0;
         evt_code_o    <= '0;
         evt_payload_o <= '0;
         utc_sec_o     <= '0;
         utc_stb_o     <= 1'b0;
         front_q       <= 1'b0;
         hi_pend_q     <= 1'b0;
         hi_q          <= '0;
         age_q         <= '0;
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < TG_DEPTH; i++) bank_q[b][i] <= '0;
      end else begin
         evt_stb_o <= 1'b0;
         utc_stb_o <= 1'b0;
         if (hi_pend_q) begin
            if (age_q == AGE_W'(MS_CYCLES - 1)) hi_pend_q <= 1'b0;
            else age_q <= age_q + AGE_W'(1);
         end
         if (hit) begin
            case (w.typ)
               TY_EVENT: begin
                  evt_stb_o     <= 1'b1;
                  evt_code_o    <= w.code;
                  evt_payload_o <= w.payload;
               end
               TY_UTC_HI: begin
                  hi_q      <= w.payload;
                  hi_pend_q <= 1'b1;
                  age_q     <= '0;
               end
               TY_UTC_LO: begin
                  if (hi_pend_q) begin
                     utc_sec_o <= {hi_q, w.payload};
                     utc_stb_o <= 1'b1;
                     hi_pend_q <= 1'b0;
                  end
               end
               TY_TGM: begin
                  if (32'(w.code) < TG_DEPTH)
                     bank_q[~front_q][w.code[IDX_W-1:0]] <= w.payload;
               end
               TY_TGM_SWAP: front_q <= ~front_q;
               default: ;
            endcase
         end
      end
   end

   AST_EVT_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stb_o |-> $past(frm_valid_i)); // R3
   AST_UTC_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      utc_stb_o |-> $past(frm_valid_i && frm_word_i[27:24] == TY_UTC_LO)); // R9
   AST_SWAP_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (front_q != $past(front_q)) |-> $past(frm_valid_i)); // R12
endmodule

// File: rtl/timing_frame_rx.sv
module timing_frame_rx #(
   parameter int OVS        = 16,
   parameter int MS_CYCLES  = 50000,
   parameter int TG_DEPTH   = 16,
   parameter int CNT_W      = 16,
   parameter bit PARITY_ODD = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        line_i,
   input  logic [3:0]                  cfg_acc_i,
   input  logic [$clog2(TG_DEPTH)-1:0] tg_rd_idx_i,
   output logic                        evt_stb_o,
   output logic [7:0]                  evt_code_o,
   output logic [15:0]                 evt_payload_o,
   output logic [31:0]                 utc_sec_o,
   output logic                        utc_stb_o,
   output logic [15:0]                 tg_rd_data_o,
   output logic [CNT_W-1:0]            rej_count_o,
   output logic [2:0]                  last_err_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("timing_frame_rx: CNT_W must be positive");
   end

   logic        frm_valid;
   logic [31:0] frm_word;
   logic [2:0]  err;

   tfr_sampler #(.OVS(OVS), .PARITY_ODD(PARITY_ODD)) u_sampler (
      .clk(clk), .rst_n(rst_n), .line_i(line_i),
      .frm_valid_o(frm_valid), .frm_word_o(frm_word), .err_o(err)
   );

   tfr_dispatch #(.MS_CYCLES(MS_CYCLES), .TG_DEPTH(TG_DEPTH)) u_dispatch (
      .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid), .frm_word_i(frm_word),
      .cfg_acc_i(cfg_acc_i), .tg_rd_idx_i(tg_rd_idx_i),
      .evt_stb_o(evt_stb_o), .evt_code_o(evt_code_o), .evt_payload_o(evt_payload_o),
      .utc_sec_o(utc_sec_o), .utc_stb_o(utc_stb_o), .tg_rd_data_o(tg_rd_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rej_count_o <= '0;
         last_err_o  <= '0;
      end else if (|err) begin
         rej_count_o <= rej_count_o + CNT_W'(1);
         last_err_o  <= err;
      end
   end

   AST_REJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rej_count_o != $past(rej_count_o)) |-> $past(|err)); // R7
endmodule

// File: tb/timing_frame_rx_tb.sv
`timescale 1ns/1ps
module timing_frame_rx_tb;
   localparam int OVS = 16, MS = 1000, DEPTH = 8, CW = 8;

   logic clk = 1'b0, rst_n = 1'b0, line = 1'b1;
   logic [3:0] cfg_acc = 4'h3;
   logic [2:0] rd_idx = '0;
   logic evt_stb, utc_stb;
   logic [7:0] evt_code;
   logic [15:0] evt_pl, rd_data;
   logic [31:0] utc;
   logic [CW-1:0] rej;
   logic [2:0] lerr;

   timing_frame_rx #(.OVS(OVS), .MS_CYCLES(MS), .TG_DEPTH(DEPTH), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_i(line), .cfg_acc_i(cfg_acc), .tg_rd_idx_i(rd_idx),
      .evt_stb_o(evt_stb), .evt_code_o(evt_code), .evt_payload_o(evt_pl),
      .utc_sec_o(utc), .utc_stb_o(utc_stb), .tg_rd_data_o(rd_data),
      .rej_count_o(rej), .last_err_o(lerr));

   always #2 clk = ~clk;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 1'b0;

   // reference model state
   int m_evt_n = 0, seen_evt_n = 0;
   logic [7:0] m_code = '0, seen_code = '0;
   logic [15:0] m_pl = '0, seen_pl = '0;
   logic [31:0] m_utc = '0;
   int m_rej = 0;
   logic [2:0] m_err = '0;
   logic [15:0] m_bank [2][DEPTH];
   int m_front = 0;
   bit m_hi_pend = 1'b0;
   logic [15:0] m_hi = '0;
   int m_hi_time = 0;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // per-clock monitor: count and latch event strobes, compare stable outputs
   always @(negedge clk) begin
      cyc++;
      if (rst_n && evt_stb) begin
         seen_evt_n++;
         seen_code = evt_code;
         seen_pl = evt_pl;
      end
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: got %0d expected <150000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic half(input logic v);
      repeat (OVS / 2) begin
         @(posedge clk);
         line <= v;
      end
   endtask

   // mode: 0 clean, 1 bad Manchester cell, 2 parity flipped, 3 stop bit 0
   task automatic send(input logic [31:0] d, input int mode);
      logic [34:0] bits;
      bits = {1'b0, d, (^d) ^ (mode == 2), (mode != 3)};
      for (int i = 34; i >= 0; i--) begin
         half(bits[i]);
         half((mode == 1 && i == 28) ? bits[i] : ~bits[i]);
      end
      half(1'b1);
      repeat (20) @(posedge clk);
      if (mode == 0) model(d);
      else begin
         m_rej++;
         m_err = (mode == 1) ? 3'b001 : (mode == 2) ? 3'b010 : 3'b100;
      end
   endtask

   task automatic model(input logic [31:0] d);
      if (!(cfg_acc == 4'hF || d[31:28] == cfg_acc)) return;
      case (d[27:24])
         4'h1: begin m_evt_n++; m_code = d[23:16]; m_pl = d[15:0]; end
         4'h2: begin m_hi_pend = 1'b1; m_hi = d[15:0]; m_hi_time = cyc; end
         4'h3: if (m_hi_pend && (cyc - m_hi_time) <= MS) begin
                  m_utc = {m_hi, d[15:0]};
                  m_hi_pend = 1'b0;
               end
         4'h4: if (d[23:16] < DEPTH) m_bank[1 - m_front][d[18:16]] = d[15:0];
         4'h5: m_front = 1 - m_front;
         default: ;
      endcase
   endtask

   task automatic check_all(input string req);
      @(negedge clk);
      chk({req, " rej_count"}, 32'(rej), 32'(m_rej));
      chk({req, " last_err"}, 32'(lerr), 32'(m_err));
      chk({req, " utc"}, utc, m_utc);
      chk({req, " evt count"}, seen_evt_n, m_evt_n);
      chk({req, " evt code"}, 32'(seen_code), 32'(m_code));
      chk({req, " evt payload"}, 32'(seen_pl), 32'(m_pl));
   endtask

   task automatic check_tg(input string req);
      for (int i = 0; i < DEPTH; i++) begin
         @(posedge clk);
         rd_idx <= 3'(i);
         @(negedge clk);
         chk(req, 32'(rd_data), 32'(m_bank[m_front][i]));
      end
   endtask

   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < DEPTH; i++) m_bank[b][i] = '0;
      repeat (5) @(posedge clk);
      rst_n <= 1'b1;
      repeat (5) @(posedge clk);
      check_all("R13 reset");
      check_tg("R13 telegram reset");

      send(32'h315A_1234, 0); check_all("R1 R2 R3 event");
      send(32'h21AA_0001, 0); check_all("R8 other selector dropped");
      cfg_acc <= 4'hF;
      send(32'h21BB_0002, 0); check_all("R8 wildcard accepts");
      cfg_acc <= 4'h3;
      send(32'h31CC_0003, 0); check_all("R3 second event");
      send(32'h31DD_0004, 1); check_all("R4 R7 Manchester reject");
      send(32'h31EE_0005, 2); check_all("R5 R7 parity reject");
      send(32'h31FF_0006, 3); check_all("R6 R7 stop reject");

      send(32'h3200_ABCD, 0);
      send(32'h3300_1357, 0); check_all("R9 time assembled");
      send(32'h3300_9999, 0); check_all("R10 low without high");
      send(32'h3200_4444, 0);
      repeat (1500) @(posedge clk);
      send(32'h3300_5555, 0); check_all("R10 late low half");
      send(32'h3200_2468, 1);
      send(32'h3300_1111, 0); check_all("R7 R10 rejected high");

      send(32'h3402_0A0A, 0);
      send(32'h3407_0B0B, 0);
      send(32'h3409_0C0C, 0);
      send(32'h3403_0D0D, 2);
      check_all("R11 writes");
      check_tg("R11 hidden writes not visible");
      send(32'h3500_0000, 0); check_all("R12 swap");
      check_tg("R12 swapped bank visible");
      send(32'h3401_7777, 0);
      send(32'h2500_0000, 0);
      check_tg("R8 R11 filtered swap, hidden write");
      send(32'h3500_0000, 0);
      check_tg("R12 second swap");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule